// File: doc/BRIEF.md
# Byte-Serviced I2C Slave Port with Status Flags

This block is the slave side of a two-wire serial bus, built for a local controller that handles one byte at a time. It watches the clock and data lines through a synchronizer, spots start and stop conditions, compares the 7-bit address against its own, and shifts bytes in and out. The bus lines are open-drain. The block never drives a line high; it only asserts a separate pull-low output for each line.

Local logic services the block through three paths. A one-byte buffer port carries bytes both ways. A status word tells local logic what the bus just did: start seen, stop seen, address or data, read or write, buffer full, write collision, receive overflow and an interrupt flag. A clock-release control ends clock stretching. In a read, the block holds the clock low after the address and after every byte the master acknowledges. It lets the clock go only when local logic sets the release bit, so local logic has time to load the next byte.

Top module: `i2c_slave_sf`

## Requirements
- R1: After reset, every status flag reads 0, the clock-release bit `ckp` reads 1, both pull-low outputs are 0 and `buf_rdata` is 0x00.
- R2: `f_start` sets on a start condition (SDA falling while SCL is high), clears `f_stop`, and stays set for the whole message. A stop condition (SDA rising while SCL is high) clears `f_start` and sets `f_stop`. The two flags are never both 1.
- R3: The master sends the address byte MSB first; bits 7..1 are the address and bit 0 is the direction, 1 meaning read. When bits 7..1 equal `OWN_ADDR`, the block pulls SDA low in the ninth clock and sets these flags: `f_full`=1, `f_data`=0, `f_read`=bit 0, `f_irq`=1. The buffer then holds the whole address byte. When the address does not match, the block does not drive SDA until the next start, and `f_full` and `f_irq` are unchanged.
- R4: In a write, each received data byte that arrives while `f_full` is 0 is acknowledged. It lands in the buffer and sets `f_full`=1, `f_data`=1, `f_read`=0 and `f_irq`=1. A `buf_rd` pulse clears `f_full`.
- R5: A data byte that arrives while `f_full` is 1 is not acknowledged (SDA is left high in the ninth clock). The buffer keeps its old contents and `f_ovf` sets. `f_ovf` stays set until an `err_clr` pulse.
- R6: A `buf_wr` pulse is rejected while `f_full` is 1 or while a transmit byte is being set up or shifted. A rejected write leaves the buffer unchanged and sets `f_wcol`, which stays set until an `err_clr` pulse.
- R7: After a read-address match, and after each transmitted byte that the master acknowledges, the block holds SCL low and `ckp` reads 0. SCL stays low even if the master releases it, until local logic pulses `ckp_set`.
- R8: After `ckp_set`, the buffer byte goes out MSB first, one bit per clock. When the eighth bit has been shifted, `f_full` reads 0 and `f_data` reads 1.
- R9: If the master does not acknowledge a transmitted byte, the block releases SDA and does not stretch SCL again. `f_start` stays 1 until the stop.
- R10: `f_irq` sets on every address match and every completed data byte, in both directions. It stays set until an `irq_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Level sensed on the bus clock line |
| sda_i | input | 1 | Level sensed on the bus data line |
| scl_drive_low | output | 1 | Pull the clock line low (stretch) |
| sda_drive_low | output | 1 | Pull the data line low (ACK or data 0) |
| buf_wr | input | 1 | Load `buf_wdata` into the buffer |
| buf_wdata | input | 8 | Transmit byte from local logic |
| buf_rd | input | 1 | Local logic has taken the buffer; clears `f_full` |
| buf_rdata | output | 8 | Buffer contents |
| ckp_set | input | 1 | Release the stretched clock |
| irq_clr | input | 1 | Clear `f_irq` |
| err_clr | input | 1 | Clear `f_wcol` and `f_ovf` |
| ckp | output | 1 | Clock-release bit, 0 while stretching |
| f_start | output | 1 | Start seen, message in progress |
| f_stop | output | 1 | Stop seen |
| f_data | output | 1 | 1 = last byte was data, 0 = address |
| f_read | output | 1 | Direction from the address LSB |
| f_full | output | 1 | Buffer full |
| f_wcol | output | 1 | Buffer write collision |
| f_ovf | output | 1 | Receive overflow |
| f_irq | output | 1 | Byte or address event pending |

## Verification
The bench acts as a bus master and waits for the line whenever the slave may stretch. One case lets a data byte arrive before the previous one was read. A design that acknowledged it or overwrote the buffer would lose data without any sign. A second case writes the buffer while the read address still sits in it. A design without collision rejection would send that byte and then lose the address. The bench also releases SCL from its own side during a stretch. A design that leaned on the master holding SCL would then let the clock run too early. The read ends with a NAK and a stop, and the bench watches SDA on every cycle after that. A slave that kept SDA low, still expecting another byte, would lock the bus until a reset.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int I2CS_DW = 8;
    localparam int I2CS_AW = I2CS_DW - 1;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_HOLD,
        ST_TXSU,
        ST_TX,
        ST_TACK
    } i2cs_state_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic data;
        logic read;
        logic full;
        logic wcol;
        logic ovf;
        logic irq;
    } i2cs_flags_t;

    function automatic logic addr_hit(input logic [I2CS_DW-1:0] rx_byte,
                                      input logic [I2CS_AW-1:0] mine);
        return rx_byte[I2CS_DW-1:1] == mine;
    endfunction

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl,
    output logic prv
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], din};
    end

    assign lvl = sh[STAGES-1];
    assign prv = sh[STAGES];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic scl_lvl,
    input  logic scl_prv,
    input  logic sda_lvl,
    input  logic sda_prv,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_steady_hi;

    assign scl_steady_hi = scl_lvl & scl_prv;
    assign scl_rise      = scl_lvl & ~scl_prv;
    assign scl_fall      = ~scl_lvl & scl_prv;
    assign start_det     = scl_steady_hi & sda_prv & ~sda_lvl;
    assign stop_det      = scl_steady_hi & ~sda_prv & sda_lvl;
endmodule

// File: rtl/i2c_slave_sf.sv
module i2c_slave_sf
    import i2cs_pkg::*;
#(
    parameter logic [I2CS_AW-1:0] OWN_ADDR    = 7'h2A,
    parameter int                 SYNC_STAGES = 2,
    parameter int                 SETUP_CYC   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               scl_drive_low,
    output logic               sda_drive_low,
    input  logic               buf_wr,
    input  logic [I2CS_DW-1:0] buf_wdata,
    input  logic               buf_rd,
    output logic [I2CS_DW-1:0] buf_rdata,
    input  logic               ckp_set,
    input  logic               irq_clr,
    input  logic               err_clr,
    output logic               ckp,
    output logic               f_start,
    output logic               f_stop,
    output logic               f_data,
    output logic               f_read,
    output logic               f_full,
    output logic               f_wcol,
    output logic               f_ovf,
    output logic               f_irq
);
    localparam int CW  = $clog2(I2CS_DW + 1);
    localparam int SUW = $clog2(SETUP_CYC + 1);
    localparam logic [CW-1:0]  BITS_DONE = CW'(I2CS_DW);
    localparam logic [CW-1:0]  LAST_TX   = CW'(I2CS_DW - 1);
    localparam logic [SUW-1:0] SU_LOAD   = SUW'(SETUP_CYC);

    // line 0 = SCL, line 1 = SDA
    logic [1:0] line_in, line_lvl, line_prv;
    logic scl_rise, scl_fall, start_det, stop_det;

    assign line_in = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_sync
            i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk (clk),
                .rst (rst),
                .din (line_in[g]),
                .lvl (line_lvl[g]),
                .prv (line_prv[g])
            );
        end
    endgenerate

    i2cs_cond u_cond (
        .scl_lvl   (line_lvl[0]),
        .scl_prv   (line_prv[0]),
        .sda_lvl   (line_lvl[1]),
        .sda_prv   (line_prv[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_state_t        st;
    i2cs_flags_t        fl;
    logic [CW-1:0]      cnt;
    logic [SUW-1:0]     su_cnt;
    logic [I2CS_DW-1:0] shreg;
    logic [I2CS_DW-1:0] bufr;
    logic               ack_q;
    logic               nak_q;
    logic               tx_busy;

    assign tx_busy = (st == ST_TX) || (st == ST_TXSU);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            fl     <= '0;
            cnt    <= '0;
            su_cnt <= '0;
            shreg  <= '0;
            bufr   <= '0;
            ack_q  <= 1'b0;
            nak_q  <= 1'b0;
            ckp    <= 1'b1;
        end else begin
            // local-logic side; bus events below take precedence
            if (irq_clr) fl.irq <= 1'b0;
            if (err_clr) begin
                fl.wcol <= 1'b0;
                fl.ovf  <= 1'b0;
            end
            if (buf_rd) fl.full <= 1'b0;
            if (buf_wr) begin
                if (fl.full || tx_busy) begin
                    fl.wcol <= 1'b1;
                end else begin
                    bufr    <= buf_wdata;
                    fl.full <= 1'b1;
                end
            end
            if (ckp_set) ckp <= 1'b1;

            if (stop_det) begin
                fl.start <= 1'b0;
                fl.stop  <= 1'b1;
                st       <= ST_IDLE;
                ckp      <= 1'b1;
            end else if (start_det) begin
                fl.start <= 1'b1;
                fl.stop  <= 1'b0;
                st       <= ST_ADDR;
                cnt      <= '0;
                ckp      <= 1'b1;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[I2CS_DW-2:0], line_lvl[1]};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == BITS_DONE) begin
                            if (addr_hit(shreg, OWN_ADDR)) begin
                                bufr    <= shreg;
                                fl.full <= 1'b1;
                                fl.data <= 1'b0;
                                fl.read <= shreg[0];
                                fl.irq  <= 1'b1;
                                st      <= ST_AACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_fall) begin
                            if (fl.read) begin
                                st  <= ST_HOLD;
                                ckp <= 1'b0;
                            end else begin
                                st  <= ST_RX;
                                cnt <= '0;
                            end
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[I2CS_DW-2:0], line_lvl[1]};
                            cnt   <= cnt + 1'b1;
                        end else if (scl_fall && cnt == BITS_DONE) begin
                            if (!fl.full) begin
                                bufr    <= shreg;
                                fl.full <= 1'b1;
                                fl.data <= 1'b1;
                                fl.read <= 1'b0;
                                ack_q   <= 1'b1;
                            end else begin
                                fl.ovf <= 1'b1;
                                ack_q  <= 1'b0;
                            end
                            fl.irq <= 1'b1;
                            st     <= ST_RACK;
                        end
                    end
                    ST_RACK: begin
                        if (scl_fall) begin
                            st    <= ST_RX;
                            cnt   <= '0;
                            ack_q <= 1'b0;
                        end
                    end
                    ST_HOLD: begin
                        if (ckp) begin
                            shreg  <= bufr;
                            su_cnt <= SU_LOAD;
                            st     <= ST_TXSU;
                        end
                    end
                    ST_TXSU: begin
                        if (su_cnt == '0) begin
                            st  <= ST_TX;
                            cnt <= '0;
                        end else begin
                            su_cnt <= su_cnt - 1'b1;
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            shreg <= {shreg[I2CS_DW-2:0], 1'b0};
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_TX) begin
                                fl.full <= 1'b0;
                                fl.data <= 1'b1;
                                st      <= ST_TACK;
                            end
                        end
                    end
                    ST_TACK: begin
                        if (scl_rise) begin
                            nak_q <= line_lvl[1];
                        end else if (scl_fall) begin
                            fl.irq <= 1'b1;
                            if (!nak_q) begin
                                st  <= ST_HOLD;
                                ckp <= 1'b0;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_drive_low = (st == ST_AACK)
                         | ((st == ST_RACK) & ack_q)
                         | (tx_busy & ~shreg[I2CS_DW-1]);
    assign scl_drive_low = (st == ST_HOLD) | (st == ST_TXSU);

    assign buf_rdata = bufr;
    assign f_start   = fl.start;
    assign f_stop    = fl.stop;
    assign f_data    = fl.data;
    assign f_read    = fl.read;
    assign f_full    = fl.full;
    assign f_wcol    = fl.wcol;
    assign f_ovf     = fl.ovf;
    assign f_irq     = fl.irq;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
    input logic clk,
    input logic rst,
    input logic buf_wr,
    input logic irq_clr,
    input logic err_clr,
    input logic ckp,
    input logic scl_drive_low,
    input logic f_start,
    input logic f_stop,
    input logic f_full,
    input logic f_wcol,
    input logic f_ovf,
    input logic f_irq
);
    // R2
    p_start_stop_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(f_start && f_stop));

    // R5
    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (f_ovf && !err_clr) |=> f_ovf);

    // R6
    p_wr_full_wcol_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && f_full) |=> f_wcol);

    // R6
    p_wcol_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (f_wcol && !err_clr) |=> f_wcol);

    // R7
    p_hold_while_ckp_low_r7: assert property (@(posedge clk) disable iff (rst)
        !ckp |-> scl_drive_low);

    // R10
    p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (f_irq && !irq_clr) |=> f_irq);
endmodule

bind i2c_slave_sf i2cs_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .buf_wr        (buf_wr),
    .irq_clr       (irq_clr),
    .err_clr       (err_clr),
    .ckp           (ckp),
    .scl_drive_low (scl_drive_low),
    .f_start       (f_start),
    .f_stop        (f_stop),
    .f_full        (f_full),
    .f_wcol        (f_wcol),
    .f_ovf         (f_ovf),
    .f_irq         (f_irq)
);

// File: tb/i2c_slave_sf_tb_top.sv
`timescale 1ns/1ps
module i2c_slave_sf_tb_top;
    localparam int H = 16;
    localparam logic [6:0] ADDR = 7'h2A;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic m_scl = 1'b1, m_sda = 1'b1;
    logic buf_wr = 0, buf_rd = 0, ckp_set = 0, irq_clr = 0, err_clr = 0;
    logic [7:0] buf_wdata = 8'h00;
    logic scl_drive_low, sda_drive_low, ckp;
    logic [7:0] buf_rdata;
    logic f_start, f_stop, f_data, f_read, f_full, f_wcol, f_ovf, f_irq;
    logic scl_line, sda_line;

    assign scl_line = m_scl & ~scl_drive_low;
    assign sda_line = m_sda & ~sda_drive_low;

    i2c_slave_sf #(.OWN_ADDR(ADDR)) dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_line), .sda_i(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd),
        .buf_rdata(buf_rdata), .ckp_set(ckp_set), .irq_clr(irq_clr),
        .err_clr(err_clr), .ckp(ckp), .f_start(f_start), .f_stop(f_stop),
        .f_data(f_data), .f_read(f_read), .f_full(f_full), .f_wcol(f_wcol),
        .f_ovf(f_ovf), .f_irq(f_irq)
    );

    int vectors = 0;
    int miscompares = 0;
    logic quiet_chk = 1'b0;   // model: slave must stay off SDA
    logic done = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected flag vector {start,stop,data,read,full,wcol,ovf,irq}
    function automatic logic [7:0] flags();
        return {f_start, f_stop, f_data, f_read, f_full, f_wcol, f_ovf, f_irq};
    endfunction

    always @(negedge clk) begin
        if (!rst && quiet_chk) begin
            vectors++;
            if (sda_drive_low !== 1'b0) begin
                miscompares++;
                $display("FAIL R3/R9 sda_drive_low actual=%0b expected=0", sda_drive_low);
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: buf_wr = 1; 1: buf_rd = 1; 2: ckp_set = 1; 3: irq_clr = 1; default: err_clr = 1;
        endcase
        @(negedge clk);
        buf_wr = 0; buf_rd = 0; ckp_set = 0; irq_clr = 0; err_clr = 0;
        wclk(2);
    endtask

    task automatic scl_up();
        m_scl = 1;
        while (scl_line !== 1'b1) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1; m_scl = 1; wclk(H);
        m_sda = 0; wclk(H);
        m_scl = 0; wclk(H);
    endtask

    task automatic do_stop();
        m_sda = 0; wclk(H);
        scl_up(); wclk(H);
        m_sda = 1; wclk(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wclk(H);
            scl_up(); wclk(H);
            m_scl = 0; wclk(4);
        end
        m_sda = 1; wclk(H);
        scl_up(); wclk(H / 2);
        ack = ~sda_line;
        wclk(H / 2);
        m_scl = 0; wclk(8);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            wclk(H);
            scl_up(); wclk(H / 2);
            b[i] = sda_line;
            wclk(H / 2);
            m_scl = 0; wclk(4);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wclk(H);
        scl_up(); wclk(H);
        m_scl = 0; wclk(4);
        m_sda = 1; wclk(8);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rb;
        wclk(4);
        rst = 0;
        wclk(4);
        // R1 reset state
        chk("R1 flags", flags(), 8'h00);
        chk("R1 ckp", ckp, 1);
        chk("R1 drives", {scl_drive_low, sda_drive_low}, 2'b00);
        chk("R1 rdata", buf_rdata, 8'h00);

        // ---- write transaction ----
        do_start();
        chk("R2 start sets", flags(), 8'b1000_0000);
        send_byte({ADDR, 1'b0}, ack);
        chk("R3 addr ack", ack, 1);
        chk("R3 addr flags", flags(), 8'b1000_1001);
        chk("R3 addr in buffer", buf_rdata, {ADDR, 1'b0});
        pulse(1); pulse(3);
        send_byte(8'hA5, ack);
        chk("R4 data ack", ack, 1);
        chk("R4 data flags", flags(), 8'b1010_1001);
        chk("R4 data value", buf_rdata, 8'hA5);
        pulse(1);
        chk("R4 buf_rd clears full", f_full, 0);
        pulse(3);
        chk("R10 irq_clr", f_irq, 0);
        send_byte(8'h3C, ack);
        chk("R4 second byte ack", ack, 1);
        pulse(3);
        send_byte(8'h0F, ack);
        chk("R5 overflow nak", ack, 0);
        chk("R5 overflow flags", flags(), 8'b1010_1011);
        chk("R5 buffer kept", buf_rdata, 8'h3C);
        buf_wdata = 8'h77; pulse(0);
        chk("R6 wcol set", f_wcol, 1);
        chk("R6 buffer unchanged", buf_rdata, 8'h3C);
        wclk(20);
        chk("R6 wcol sticky", f_wcol, 1);
        chk("R5 ovf sticky", f_ovf, 1);
        pulse(4);
        chk("R6 err_clr", {f_wcol, f_ovf}, 2'b00);
        pulse(1); pulse(3);
        do_stop();
        chk("R2 stop flags", flags(), 8'b0110_0000);

        // ---- address mismatch ----
        do_start();
        quiet_chk = 1;
        send_byte({7'h15, 1'b0}, ack);
        chk("R3 mismatch no ack", ack, 0);
        send_byte(8'hFF, ack);
        chk("R3 mismatch data ignored", flags(), 8'b1010_0000);
        do_stop();
        quiet_chk = 0;
        chk("R2 stop after mismatch", flags(), 8'b0110_0000);

        // ---- read transaction ----
        do_start();
        chk("R2 start clears stop", {f_start, f_stop}, 2'b10);
        send_byte({ADDR, 1'b1}, ack);
        chk("R3 read addr ack", ack, 1);
        chk("R3 read addr flags", flags(), 8'b1001_1001);
        chk("R7 stretch after addr", scl_drive_low, 1);
        chk("R7 ckp low", ckp, 0);
        buf_wdata = 8'h96; pulse(0);
        chk("R6 early write wcol", f_wcol, 1);
        chk("R6 addr still in buffer", buf_rdata, {ADDR, 1'b1});
        pulse(4); pulse(1);
        buf_wdata = 8'h96; pulse(0);
        chk("R6 accepted write", {f_full, f_wcol, buf_rdata}, {2'b10, 8'h96});
        pulse(3);
        m_scl = 1; wclk(40);
        chk("R7 scl held with master released", scl_line, 0);
        m_scl = 0; wclk(4);
        pulse(2);
        wclk(10);
        chk("R7 released after ckp_set", {scl_drive_low, ckp}, 2'b01);
        recv_byte(1'b1, rb);
        chk("R8 first byte", rb, 8'h96);
        chk("R7 stretch after acked byte", scl_drive_low, 1);
        chk("R8 flags after byte", flags(), 8'b1011_0001);
        pulse(3);
        buf_wdata = 8'h5A; pulse(0);
        pulse(2);
        wclk(10);
        recv_byte(1'b0, rb);
        chk("R8 second byte", rb, 8'h5A);
        quiet_chk = 1;
        wclk(40);
        chk("R9 released after nak", {scl_drive_low, sda_drive_low}, 2'b00);
        chk("R9 start held", f_start, 1);
        chk("R10 irq on last byte", f_irq, 1);
        do_stop();
        quiet_chk = 0;
        chk("R2 stop after read", {f_start, f_stop}, 2'b01);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule